// File: doc/BRIEF.md
# MII Receive Nibble Decoder

This block sits on the MAC side of a four-bit media-independent interface and turns the receive nibble stream into bytes. On every receive clock it registers the data valid, error and four data lines, and decides whether the cycle is gap, good data, errored data or a false-carrier indication. While a frame is in progress it drops the preamble. Once the start-of-frame delimiter has been seen, it pairs nibbles into bytes, low nibble first.

Downstream logic gets a byte strobe, a start-of-frame pulse on the first byte, and an end-of-frame pulse. The end-of-frame pulse carries an error flag and an alignment flag. Two saturating event counters are kept, one for false-carrier indications and one for errored frames. They share a synchronous clear input.

Top module: `mii_rx_decoder`

## Requirements
- R1: After reset every strobe and flag output is 0 and both counters read 0.
- R2: A cycle with data valid low and error low produces no output of any kind, whatever the data lines carry.
- R3: After data valid rises, every nibble is discarded until the nibble 1101 is seen. That nibble is the upper half of the delimiter byte 0xD5 sent low half first, and the first data nibble follows it.
- R4: After the delimiter, two nibbles form one byte. The first nibble is bits 3:0 and the second is bits 7:4. The byte strobe is high for one cycle, two clock cycles after the second nibble is presented.
- R5: The start-of-frame pulse is high together with the byte strobe of the first byte of each frame, and at no other time.
- R6: The first cycle with data valid low after a frame whose delimiter was seen produces a one-cycle end-of-frame pulse, at the same two-cycle latency. A burst in which no delimiter was seen ends silently.
- R7: The frame error flag is high with the end-of-frame pulse if error was high on any cycle with data valid high since data valid rose, preamble included.
- R8: The alignment error flag is high with the end-of-frame pulse if an odd number of nibbles followed the delimiter.
- R9: Data valid low, error high and data 1110 gives a one-cycle false-carrier pulse and adds one to the false-carrier counter. It never produces a byte.
- R10: Data valid low and error high with any data other than 1110 has no effect on any output.
- R11: The errored-frame counter adds one in the same cycle as an end-of-frame pulse whose frame error flag is high.
- R12: Both counters stop at 65535 and do not wrap.
- R13: The clear input, sampled like the receive lines, zeroes both counters two cycles later. It wins over an increment caused in the same sampled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_dv_i | input | 1 | Receive data valid |
| rx_er_i | input | 1 | Receive error |
| rxd_i | input | 4 | Receive data nibble |
| cnt_clr_i | input | 1 | Synchronous clear of both counters |
| rx_byte_o | output | 8 | Assembled byte |
| rx_byte_vld_o | output | 1 | Byte strobe |
| rx_sof_o | output | 1 | Start-of-frame pulse, with first byte |
| rx_eof_o | output | 1 | End-of-frame pulse |
| rx_frame_err_o | output | 1 | Frame had a reception error (valid with end-of-frame) |
| rx_align_err_o | output | 1 | Odd trailing nibble (valid with end-of-frame) |
| false_carrier_o | output | 1 | False-carrier event pulse |
| fc_count_o | output | 16 | False-carrier event count, saturating |
| bad_frame_count_o | output | 16 | Errored frame count, saturating |

## Verification
A wrong nibble phase appears as swapped byte halves or a shifted byte, and the reference comparison catches it two cycles after the second nibble. A frame state left stale shows up at the next data-valid fall: the end-of-frame pulse is missing or extra, or its flags are wrong. A delimiter missed in the preamble leaves no bytes at all. A false-carrier decode or counter fault is visible on the pulse or the count two cycles after the triggering nibble. Saturation is driven past the limit to expose any wrap.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    localparam logic [NIB_W-1:0] NIB_DELIM_HI = 4'b1101;
    localparam logic [NIB_W-1:0] NIB_FCARRIER = 4'b1110;

    typedef enum logic [1:0] {
        CLS_GAP,
        CLS_DATA,
        CLS_DATA_ERR,
        CLS_FCAR
    } rx_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DATA
    } rx_st_e;

    typedef struct packed {
        logic             dv;
        logic             er;
        logic [NIB_W-1:0] nib;
        logic             clr;
    } rx_smp_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              vld;
        logic              sof;
        logic              eof;
        logic              ferr;
        logic              aerr;
        logic              fcar;
    } rx_out_t;

    function automatic rx_cls_e classify(input rx_smp_t s);
        rx_cls_e c;
        if (s.dv)
            c = s.er ? CLS_DATA_ERR : CLS_DATA;
        else if (s.er && s.nib == NIB_FCARRIER)
            c = CLS_FCAR;
        else
            c = CLS_GAP;
        return c;
    endfunction

endpackage

// File: rtl/mii_rx_sampler.sv
module mii_rx_sampler
    import mii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dv_i,
    input  logic             er_i,
    input  logic [NIB_W-1:0] nib_i,
    input  logic             clr_i,
    output rx_smp_t          smp_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_o <= '0;
        end else begin
            smp_o.dv  <= dv_i;
            smp_o.er  <= er_i;
            smp_o.nib <= nib_i;
            smp_o.clr <= clr_i;
        end
    end

endmodule

// File: rtl/mii_rx_assembler.sv
module mii_rx_assembler
    import mii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rx_cls_e          cls_i,
    input  logic [NIB_W-1:0] nib_i,
    output rx_out_t          out_o,
    output logic             bad_frame_ev_o
);

    rx_st_e           st_q;
    logic             phase_q;
    logic             first_q;
    logic             err_q;
    logic [NIB_W-1:0] low_q;

    logic is_dv, is_er;
    assign is_dv = (cls_i == CLS_DATA) || (cls_i == CLS_DATA_ERR);
    assign is_er = (cls_i == CLS_DATA_ERR);

    // errored frame closes in this cycle
    assign bad_frame_ev_o = !is_dv && (st_q == ST_DATA) && err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            phase_q <= 1'b0;
            first_q <= 1'b0;
            err_q   <= 1'b0;
            low_q   <= '0;
            out_o   <= '0;
        end else begin
            out_o.vld  <= 1'b0;
            out_o.sof  <= 1'b0;
            out_o.eof  <= 1'b0;
            out_o.ferr <= 1'b0;
            out_o.aerr <= 1'b0;
            out_o.fcar <= (cls_i == CLS_FCAR);
            if (is_dv) begin
                err_q <= ((st_q == ST_IDLE) ? 1'b0 : err_q) | is_er;
                if (st_q == ST_DATA) begin
                    if (!phase_q) begin
                        low_q   <= nib_i;
                        phase_q <= 1'b1;
                    end else begin
                        out_o.data <= {nib_i, low_q};
                        out_o.vld  <= 1'b1;
                        out_o.sof  <= first_q;
                        first_q    <= 1'b0;
                        phase_q    <= 1'b0;
                    end
                end else if (nib_i == NIB_DELIM_HI) begin
                    st_q    <= ST_DATA;
                    phase_q <= 1'b0;
                    first_q <= 1'b1;
                end else begin
                    st_q <= ST_HUNT;
                end
            end else begin
                if (st_q == ST_DATA) begin
                    out_o.eof  <= 1'b1;
                    out_o.ferr <= err_q;
                    out_o.aerr <= phase_q;
                end
                st_q    <= ST_IDLE;
                phase_q <= 1'b0;
            end
        end
    end

    // R5
    sof_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
        out_o.sof |-> out_o.vld);

    // R6
    eof_not_byte_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_o.eof && out_o.vld));

    // R8
    align_only_at_eof_chk: assert property (@(posedge clk) disable iff (rst)
        out_o.aerr |-> out_o.eof);

    // R7
    ferr_only_at_eof_chk: assert property (@(posedge clk) disable iff (rst)
        out_o.ferr |-> out_o.eof);

endmodule

// File: rtl/mii_rx_sat_counter.sv
module mii_rx_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_o <= '0;
        else if (inc_i && cnt_o != CNT_MAX)
            cnt_o <= cnt_o + 1'b1;
    end

    // R12
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX);

    // R12
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> cnt_o >= $past(cnt_o));

    // R13
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_o == '0);

endmodule

// File: rtl/mii_rx_decoder.sv
module mii_rx_decoder
    import mii_rx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_dv_i,
    input  logic              rx_er_i,
    input  logic [NIB_W-1:0]  rxd_i,
    input  logic              cnt_clr_i,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_byte_vld_o,
    output logic              rx_sof_o,
    output logic              rx_eof_o,
    output logic              rx_frame_err_o,
    output logic              rx_align_err_o,
    output logic              false_carrier_o,
    output logic [CNT_W-1:0]  fc_count_o,
    output logic [CNT_W-1:0]  bad_frame_count_o
);

    localparam int NCNT   = 2;
    localparam int IX_FC  = 0;
    localparam int IX_BAD = 1;

    rx_smp_t smp;
    rx_cls_e cls;
    rx_out_t out;
    logic    bad_ev;

    logic [NCNT-1:0]  cnt_inc;
    logic [CNT_W-1:0] cnt_val [NCNT];

    mii_rx_sampler u_smp (
        .clk   (clk),
        .rst   (rst),
        .dv_i  (rx_dv_i),
        .er_i  (rx_er_i),
        .nib_i (rxd_i),
        .clr_i (cnt_clr_i),
        .smp_o (smp)
    );

    assign cls = classify(smp);

    mii_rx_assembler u_asm (
        .clk            (clk),
        .rst            (rst),
        .cls_i          (cls),
        .nib_i          (smp.nib),
        .out_o          (out),
        .bad_frame_ev_o (bad_ev)
    );

    assign cnt_inc[IX_FC]  = (cls == CLS_FCAR);
    assign cnt_inc[IX_BAD] = bad_ev;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        mii_rx_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr_i (smp.clr),
            .inc_i (cnt_inc[g]),
            .cnt_o (cnt_val[g])
        );
    end

    assign rx_byte_o         = out.data;
    assign rx_byte_vld_o     = out.vld;
    assign rx_sof_o          = out.sof;
    assign rx_eof_o          = out.eof;
    assign rx_frame_err_o    = out.ferr;
    assign rx_align_err_o    = out.aerr;
    assign false_carrier_o   = out.fcar;
    assign fc_count_o        = cnt_val[IX_FC];
    assign bad_frame_count_o = cnt_val[IX_BAD];

    // R9
    fcar_not_data_chk: assert property (@(posedge clk) disable iff (rst)
        false_carrier_o |-> !(rx_byte_vld_o || rx_eof_o));

    // R9
    fcar_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (false_carrier_o && !$past(smp.clr) && $past(fc_count_o) != {CNT_W{1'b1}})
            |-> fc_count_o == $past(fc_count_o) + 1'b1);

endmodule

// File: tb/sim_mii_rx_decoder.sv
module sim_mii_rx_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dv = 1'b0, er = 1'b0, clr = 1'b0;
    logic [3:0] nib = 4'h0;

    logic [7:0]  byte_o;
    logic        vld_o, sof_o, eof_o, ferr_o, aerr_o, fcar_o;
    logic [15:0] fcc_o, bfc_o;

    always #10 clk = ~clk;

    mii_rx_decoder u0 (
        .clk(clk), .rst(rst), .rx_dv_i(dv), .rx_er_i(er), .rxd_i(nib),
        .cnt_clr_i(clr), .rx_byte_o(byte_o), .rx_byte_vld_o(vld_o),
        .rx_sof_o(sof_o), .rx_eof_o(eof_o), .rx_frame_err_o(ferr_o),
        .rx_align_err_o(aerr_o), .false_carrier_o(fcar_o),
        .fc_count_o(fcc_o), .bad_frame_count_o(bfc_o)
    );

    typedef struct {
        int data; bit vld, sof, eof, ferr, aerr, fcar; int fcc, bfc;
    } exp_t;

    int   n_tests = 0, n_fail = 0;
    bit   done = 0;
    exp_t d1, d2, zero_e;
    int   m_st = 0, m_ph = 0, m_low = 0, m_first = 0, m_err = 0;
    int   m_fc = 0, m_bf = 0;
    int   ob_bytes = 0, ob_sof = 0, ob_eof = 0, ob_ferr = 0, ob_aerr = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic exp_t model(input bit d, input bit e, input int n, input bit c);
        exp_t r = zero_e;
        bit bad = 0;
        r.fcar = (!d && e && n == 14);
        if (d) begin
            m_err = (m_st == 0) ? int'(e) : (m_err | int'(e));
            if (m_st == 2) begin
                if (m_ph == 0) begin
                    m_low = n; m_ph = 1;
                end else begin
                    r.vld = 1; r.data = n * 16 + m_low;
                    r.sof = (m_first != 0); m_first = 0; m_ph = 0;
                end
            end else if (n == 13) begin
                m_st = 2; m_ph = 0; m_first = 1;
            end else m_st = 1;
        end else begin
            if (m_st == 2) begin
                r.eof = 1; r.ferr = (m_err != 0); r.aerr = (m_ph != 0);
                bad = (m_err != 0);
            end
            m_st = 0; m_ph = 0;
        end
        if (c) begin m_fc = 0; m_bf = 0; end
        else begin
            if (r.fcar && m_fc < 65535) m_fc++;
            if (bad && m_bf < 65535) m_bf++;
        end
        r.fcc = m_fc; r.bfc = m_bf;
        return r;
    endfunction

    task automatic step(input bit d, input bit e, input int n, input bit c);
        @(negedge clk);
        if (vld_o) ob_bytes++;
        if (sof_o) ob_sof++;
        if (eof_o) ob_eof++;
        if (ferr_o) ob_ferr++;
        if (aerr_o) ob_aerr++;
        chk("R4 byte strobe", int'(vld_o), int'(d2.vld));
        if (d2.vld) chk("R4 byte value", int'(byte_o), d2.data);
        chk("R5 sof", int'(sof_o), int'(d2.sof));
        chk("R6 eof", int'(eof_o), int'(d2.eof));
        chk("R7 frame error", int'(ferr_o), int'(d2.ferr));
        chk("R8 align error", int'(aerr_o), int'(d2.aerr));
        chk("R9 false carrier pulse", int'(fcar_o), int'(d2.fcar));
        chk("R12 fc count", int'(fcc_o), d2.fcc);
        chk("R11 bad frame count", int'(bfc_o), d2.bfc);
        d2 = d1;
        dv = d; er = e; nib = n[3:0]; clr = c;
        d1 = model(d, e, n, c);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0);
    endtask

    task automatic send_frame(input int bytes[$], input int err_nib, input bit odd,
                              input int pre_err);
        for (int i = 0; i < 15; i++) step(1, (i == pre_err), 5, 0);
        step(1, 0, 13, 0);
        for (int i = 0; i < bytes.size(); i++) begin
            step(1, (2*i == err_nib), bytes[i] % 16, 0);
            step(1, (2*i+1 == err_nib), bytes[i] / 16, 0);
        end
        if (odd) step(1, 0, 9, 0);
        idle(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int b0, e0, s0;
        zero_e = '{default: 0};
        d1 = zero_e; d2 = zero_e;
        rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        idle(3);
        // R1 reset state
        chk("R1 byte strobe", int'(vld_o), 0);
        chk("R1 eof", int'(eof_o), 0);
        chk("R1 fc count", int'(fcc_o), 0);
        chk("R1 bad frame count", int'(bfc_o), 0);

        // R2 gap with arbitrary data lines
        b0 = ob_bytes; e0 = ob_eof;
        for (int i = 0; i < 16; i++) step(0, 0, i, 0);
        idle(2);
        chk("R2 no bytes in gap", ob_bytes - b0, 0);
        chk("R2 no eof in gap", ob_eof - e0, 0);

        // R4 R5 clean frame
        b0 = ob_bytes; s0 = ob_sof; e0 = ob_eof;
        send_frame('{8'h11, 8'h22, 8'hA5, 8'hFF, 8'h00, 8'h3C}, -1, 0, -1);
        chk("R4 byte count", ob_bytes - b0, 6);
        chk("R5 one sof", ob_sof - s0, 1);
        chk("R6 one eof", ob_eof - e0, 1);

        // R7 R11 error in data
        send_frame('{8'h12, 8'h34, 8'h56, 8'h78}, 3, 0, -1);
        chk("R11 bad count after errored frame", int'(bfc_o), 1);

        // R7 error during preamble
        e0 = ob_ferr;
        send_frame('{8'h9A, 8'hBC}, -1, 0, 4);
        chk("R7 preamble error flagged", ob_ferr - e0, 1);

        // R8 odd trailing nibble
        e0 = ob_aerr;
        send_frame('{8'hDE, 8'hAD, 8'hBE}, -1, 1, -1);
        chk("R8 align flagged", ob_aerr - e0, 1);

        // R3 burst without delimiter ends silently
        e0 = ob_eof; b0 = ob_bytes;
        for (int i = 0; i < 10; i++) step(1, 0, 5, 0);
        idle(3);
        chk("R3 no eof without delimiter", ob_eof - e0, 0);
        chk("R3 no bytes without delimiter", ob_bytes - b0, 0);

        // R3 junk nibbles before delimiter are dropped
        b0 = ob_bytes;
        step(1, 0, 0, 0); step(1, 0, 10, 0); step(1, 0, 5, 0); step(1, 0, 13, 0);
        step(1, 0, 7, 0); step(1, 0, 4, 0);
        idle(3);
        chk("R3 one byte after junk preamble", ob_bytes - b0, 1);

        // R10 reserved codes
        s0 = int'(fcc_o);
        for (int i = 0; i < 16; i++) if (i != 14) step(0, 1, i, 0);
        idle(2);
        chk("R10 reserved codes ignored", int'(fcc_o), s0);

        // R9 false carrier events
        for (int i = 0; i < 3; i++) step(0, 1, 14, 0);
        idle(2);
        chk("R9 fc count", int'(fcc_o), s0 + 3);

        // R13 clear coinciding with an event
        step(0, 1, 14, 1);
        idle(2);
        chk("R13 fc cleared", int'(fcc_o), 0);
        chk("R13 bad count cleared", int'(bfc_o), 0);

        // R12 saturation
        for (int i = 0; i < 65540; i++) step(0, 1, 14, 0);
        idle(2);
        chk("R12 fc saturates", int'(fcc_o), 65535);

        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule